// File: doc/BRIEF.md
# Dual Field Memory Control Generator

This block drives the write-enable and back-channel output-enable strobes for two external field memories, called A and B. Incoming video fields go to the memories according to a 3-bit write-mode code. That code can alternate the two memories, freeze either one or both, send every field to one memory, or send only every second field to one memory. A field-phase flag, derived from the vertical sync and the active-line indicator, gives the strobe pattern a period of two fields. That is one frame, at 25 Hz in a 50 Hz system.

A second function re-times the serial column-address and row-address lines. Each line passes through a fixed register delay in the block's clock domain, so the addresses stay aligned with the memory strobes.

All logic runs on one clock, `clk`, which is the serial-address clock. The sync inputs are sampled in that clock domain.

Top module: `fmc_top`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, all four enables read 0 and both address outputs read 0.
- R2: `col_addr_out` and `row_addr_out` reproduce `col_addr_in` and `row_addr_in` delayed by exactly 4 clock cycles.
- R3: A field boundary is the first clock in which `line_active` is seen rising after a rising edge of `vsync`. Each boundary toggles the field phase. The first field after reset is an A field, and A and B fields then alternate.
- R4: Write mode 3'b000 drives `wen_a` high during A fields and `wen_b` high during B fields.
- R5: Write mode 3'b001, and the reserved codes 3'b110 and 3'b111, hold both `wen_a` and `wen_b` low.
- R6: Write mode 3'b010 holds `wen_b` high and `wen_a` low on every field. Write mode 3'b100 holds `wen_a` high and `wen_b` low on every field.
- R7: Write mode 3'b011 raises `wen_b` only during B fields and keeps `wen_a` low. Write mode 3'b101 raises `wen_a` only during A fields and keeps `wen_b` low.
- R8: After the first boundary, exactly one of `oen_a` and `oen_b` is high. `oen_a` is high during A fields. The exception is write mode 3'b000 with `nr_field_delay` = 1: there the enables swap, and `oen_a` is high during B fields.
- R9: The enables change only in the clock of a field boundary. A change of `wr_mode` or `nr_field_delay` in mid-field takes effect at the next boundary.
- R10: A shift of ±1 clock in the rising edge of `line_active` neither adds nor removes a field boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-address clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| vsync | input | 1 | Field-rate vertical sync, active high |
| line_active | input | 1 | High during the active part of a line |
| wr_mode | input | 3 | Write-mode code |
| nr_field_delay | input | 1 | 1: back channel one field behind (mode 000 only) |
| col_addr_in | input | 1 | Serial column address in |
| row_addr_in | input | 1 | Serial row address in |
| wen_a | output | 1 | Write enable, memory A |
| wen_b | output | 1 | Write enable, memory B |
| oen_a | output | 1 | Back-channel output enable, memory A |
| oen_b | output | 1 | Back-channel output enable, memory B |
| col_addr_out | output | 1 | Delayed serial column address |
| row_addr_out | output | 1 | Delayed serial row address |

## Verification
The bench runs fields of short lines through all eight write-mode codes, and mode 000 with both delay settings. Each run separates the alternating, frozen, redirected and every-second-field behaviours by comparing the field phase against which strobe rises.

The mode is changed in the middle of a field, so a design that reacts to the change at once differs from one that waits for the boundary.

Every active-line edge is shifted at random by up to one clock. A design that double-counts or misses a boundary therefore gets its phase out of step.

Random address bits each cycle expose any delay other than four clocks.

// File: rtl/fmc_pkg.sv
// Package: shared write-mode codes and the strobe-set type for the
// field memory control generator.
package fmc_pkg;

    localparam int WM_W = 3;

    localparam logic [WM_W-1:0] WM_ALTERNATE = 3'b000;
    localparam logic [WM_W-1:0] WM_FREEZE    = 3'b001;
    localparam logic [WM_W-1:0] WM_ALL_TO_B  = 3'b010;
    localparam logic [WM_W-1:0] WM_HALF_B    = 3'b011;
    localparam logic [WM_W-1:0] WM_ALL_TO_A  = 3'b100;
    localparam logic [WM_W-1:0] WM_HALF_A    = 3'b101;

    typedef struct packed {
        logic wen_a;
        logic wen_b;
        logic oen_a;
        logic oen_b;
    } strobe_t;

endpackage

// File: rtl/fmc_field_sync.sv
// Field boundary detector and field-phase flag.
// A rising vsync arms the detector. The first rising edge of line_active
// after that is the field boundary, and it toggles the phase.
// Assumes: vsync and line_active are synchronous to clk. Because the
// detector waits for an edge, a shift of the blanking edge by a clock or
// two does not change how many boundaries are seen.
module fmc_field_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync,
    input  logic line_active,
    output logic fld_start,
    output logic field_b
);

    logic vs_q;
    logic ln_q;
    logic armed;
    logic vs_rise;

    assign vs_rise   = vsync & ~vs_q;
    assign fld_start = armed & line_active & ~ln_q;

    // Keep the previous samples of the sync inputs for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q <= 1'b0;
            ln_q <= 1'b0;
        end else begin
            vs_q <= vsync;
            ln_q <= line_active;
        end
    end

    // Arm on vsync, disarm once the qualifying active line is found.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= vs_rise | (armed & ~fld_start);
        end
    end

    // Toggle the field phase on each boundary; reset so the first field is A.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_b <= 1'b1;
        end else if (fld_start) begin
            field_b <= ~field_b;
        end
    end

    // R3: a boundary is only ever declared on an active-line sample
    a_r3_start_on_active: assert property (@(posedge clk) disable iff (!rst_n)
        fld_start |-> (line_active && !ln_q));

    // R3: the phase flag moves only at a boundary
    a_r3_phase_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !fld_start |=> $stable(field_b));

endmodule

// File: rtl/fmc_enable_gen.sv
// Write and back-channel enable generator.
// At each field boundary it works out the four strobes from the write mode,
// the phase of the field that is starting and the noise-reduction delay
// bit, then holds them for the whole field.
// Assumes: fld_start is one clock wide, and field_b is the phase before the
// boundary toggles it.
module fmc_enable_gen
    import fmc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fld_start,
    input  logic            field_b,
    input  logic [WM_W-1:0] wr_mode,
    input  logic            nr_field_delay,
    output strobe_t         strobes
);

    logic    nxt_b;
    logic    fd_swap;
    strobe_t nxt;

    assign nxt_b   = ~field_b;
    assign fd_swap = nr_field_delay & (wr_mode == WM_ALTERNATE);

    // Decode the strobe set for the field that is about to start.
    always_comb begin
        nxt = '0;
        unique case (wr_mode)
            WM_ALTERNATE: begin
                nxt.wen_a = ~nxt_b;
                nxt.wen_b = nxt_b;
            end
            WM_ALL_TO_B: nxt.wen_b = 1'b1;
            WM_HALF_B:   nxt.wen_b = nxt_b;
            WM_ALL_TO_A: nxt.wen_a = 1'b1;
            WM_HALF_A:   nxt.wen_a = ~nxt_b;
            default: begin
                nxt.wen_a = 1'b0;
                nxt.wen_b = 1'b0;
            end
        endcase
        nxt.oen_a = (~nxt_b) ^ fd_swap;
        nxt.oen_b = ~nxt.oen_a;
    end

    // Load the strobes only at a field boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobes <= '0;
        end else if (fld_start) begin
            strobes <= nxt;
        end
    end

    // R9: no strobe moves inside a field
    a_r9_hold_mid_field: assert property (@(posedge clk) disable iff (!rst_n)
        !fld_start |=> $stable(strobes));

    // R8: at most one back channel is open at any time
    a_r8_one_back_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({strobes.oen_a, strobes.oen_b}));

    // R8: after any boundary exactly one back channel is open
    a_r8_open_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        fld_start |=> $countones({strobes.oen_a, strobes.oen_b}) == 1);

    // R5: freeze and reserved codes leave both memories unwritten
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_start && (wr_mode == WM_FREEZE || wr_mode[2:1] == 2'b11))
        |=> (!strobes.wen_a && !strobes.wen_b));

    // R6: redirect codes write one memory every field
    a_r6_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_start && (wr_mode == WM_ALL_TO_B || wr_mode == WM_ALL_TO_A))
        |=> (strobes.wen_a == $past(wr_mode[2]) && strobes.wen_b == !$past(wr_mode[2])));

endmodule

// File: rtl/fmc_addr_delay.sv
// Fixed-length delay line for the serial address lines.
// Each lane passes through DEPTH registers, so an output equals its input
// DEPTH clocks earlier.
// Assumes: DEPTH >= 1. The registers clear to zero in reset.
module fmc_addr_delay #(
    parameter int WIDTH = 2,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0][WIDTH-1:0] stg;

    generate
        if (DEPTH == 1) begin : g_single
            // Single stage: capture the input directly.
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= din;
            end
        end else begin : g_chain
            // Shift the chain by one stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= {stg[DEPTH-2:0], din};
            end
        end
    endgenerate

    assign dout = stg[LAST];

    // R2: the head stage always holds the input from the previous clock
    a_r2_head_capture: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stg[0] == $past(din));

endmodule

// File: rtl/fmc_top.sv
// Dual field memory control generator, top level.
// It joins the field boundary detector, the enable generator and the
// serial address delay line.
// Assumes: a single clock domain (the serial-address clock), with all
// inputs synchronous to it.
module fmc_top #(
    parameter int ADDR_DELAY = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vsync,
    input  logic       line_active,
    input  logic [2:0] wr_mode,
    input  logic       nr_field_delay,
    input  logic       col_addr_in,
    input  logic       row_addr_in,
    output logic       wen_a,
    output logic       wen_b,
    output logic       oen_a,
    output logic       oen_b,
    output logic       col_addr_out,
    output logic       row_addr_out
);

    import fmc_pkg::*;

    localparam int LANES = 2;

    logic             fld_start;
    logic             field_b;
    strobe_t          strobes;
    logic [LANES-1:0] addr_dly;

    fmc_field_sync u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .vsync       (vsync),
        .line_active (line_active),
        .fld_start   (fld_start),
        .field_b     (field_b)
    );

    fmc_enable_gen u_en (
        .clk            (clk),
        .rst_n          (rst_n),
        .fld_start      (fld_start),
        .field_b        (field_b),
        .wr_mode        (wr_mode),
        .nr_field_delay (nr_field_delay),
        .strobes        (strobes)
    );

    fmc_addr_delay #(
        .WIDTH (LANES),
        .DEPTH (ADDR_DELAY)
    ) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({row_addr_in, col_addr_in}),
        .dout  (addr_dly)
    );

    assign wen_a        = strobes.wen_a;
    assign wen_b        = strobes.wen_b;
    assign oen_a        = strobes.oen_a;
    assign oen_b        = strobes.oen_b;
    assign col_addr_out = addr_dly[0];
    assign row_addr_out = addr_dly[1];

    // R7: half-rate modes write only the matching memory
    a_r7_half_rate_side: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_start && (wr_mode == WM_HALF_B || wr_mode == WM_HALF_A))
        |=> (wr_mode_side_ok($past(wr_mode), wen_a, wen_b)));

    function automatic logic wr_mode_side_ok(input logic [2:0] m,
                                             input logic a, input logic b);
        return (m == WM_HALF_B) ? !a : !b;
    endfunction

endmodule

// File: tb/fmc_top_tb_top.sv
// Bench: a behavioural reference model that is compared on every clock.
module fmc_top_tb_top;

    localparam int LINE_LEN  = 20;
    localparam int LINES     = 6;
    localparam int ACT_START = 6;
    localparam int ACT_END   = 17;
    localparam int FIELDS    = 3;
    localparam int NSCEN     = 10;
    localparam int WATCHDOG  = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsync = 1'b0;
    logic       line_active = 1'b0;
    logic [2:0] wr_mode = 3'b000;
    logic       nr_field_delay = 1'b0;
    logic       col_addr_in = 1'b0;
    logic       row_addr_in = 1'b0;
    logic       wen_a, wen_b, oen_a, oen_b, col_addr_out, row_addr_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // model state
    bit       m_prev_vs = 0, m_prev_ln = 0, m_armed = 0, m_fb = 1;
    bit       m_wa = 0, m_wb = 0, m_oa = 0, m_ob = 0;
    bit [2:0] m_mode = 0;
    bit [1:0] addr_q[$];
    int       oa_changes = 0;
    bit       last_oa = 0;

    always #10 clk = ~clk;   // 50 MHz

    fmc_top dut_i (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .line_active(line_active),
        .wr_mode(wr_mode), .nr_field_delay(nr_field_delay),
        .col_addr_in(col_addr_in), .row_addr_in(row_addr_in),
        .wen_a(wen_a), .wen_b(wen_b), .oen_a(oen_a), .oen_b(oen_b),
        .col_addr_out(col_addr_out), .row_addr_out(row_addr_out)
    );

    function automatic string mode_tag(input bit [2:0] m);
        case (m)
            3'b000:          return "R4";
            3'b010, 3'b100:  return "R6";
            3'b011, 3'b101:  return "R7";
            default:         return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // One clock: compare at the negative edge, drive, then advance the model.
    task automatic step(input bit vs, input bit ln);
        bit [1:0] exp_addr;
        bit [1:0] nad;
        bit       start, fd;
        @(negedge clk);
        cycles++;
        // R9 is covered here too: the model changes enables only at a boundary
        check({mode_tag(m_mode), " wen_a"}, wen_a, m_wa);
        check({mode_tag(m_mode), " wen_b"}, wen_b, m_wb);
        check("R8 oen_a", oen_a, m_oa);
        check("R8 oen_b", oen_b, m_ob);
        exp_addr = addr_q.pop_front();
        check("R2 col", col_addr_out, exp_addr[0]);
        check("R2 row", row_addr_out, exp_addr[1]);
        if (oen_a != last_oa) oa_changes++;
        last_oa = oen_a;
        nad = 2'($urandom_range(0, 3));
        vsync = vs; line_active = ln;
        col_addr_in = nad[0]; row_addr_in = nad[1];
        addr_q.push_back(nad);
        // model of the coming edge (R3: boundary on first active rise after vsync)
        start = m_armed && ln && !m_prev_ln;
        if (start) begin
            m_fb = !m_fb;
            m_mode = wr_mode;
            m_wa = 0; m_wb = 0;
            case (wr_mode)
                3'b000: begin m_wa = !m_fb; m_wb = m_fb; end
                3'b010: m_wb = 1;
                3'b011: m_wb = m_fb;
                3'b100: m_wa = 1;
                3'b101: m_wa = !m_fb;
                default: ;
            endcase
            fd = nr_field_delay && (wr_mode == 3'b000);
            m_oa = (!m_fb) ^ fd;
            m_ob = !m_oa;
        end
        m_armed = (vs && !m_prev_vs) || (m_armed && !start);
        m_prev_vs = vs;
        m_prev_ln = ln;
    endtask

    // One field of video; the mode is switched in mid-field when asked (R9).
    task automatic run_field(input bit chg, input bit [2:0] nm, input bit nd);
        for (int l = 0; l < LINES; l++) begin
            int jit = $urandom_range(0, 2) - 1;   // R10: +/-1 clock edge jitter
            if (chg && l == 2) begin
                wr_mode = nm;
                nr_field_delay = nd;
            end
            for (int c = 0; c < LINE_LEN; c++) begin
                step(l == 0 && c < 3,
                     (c >= ACT_START + jit) && (c < ACT_END));
            end
        end
    endtask

    initial begin
        bit [2:0] modes [NSCEN] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4,
                                   3'd5, 3'd6, 3'd7, 3'd0, 3'd3};
        bit       delays[NSCEN] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                   1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 wen_a", wen_a, 0);
        check("R1 wen_b", wen_b, 0);
        check("R1 oen_a", oen_a, 0);
        check("R1 oen_b", oen_b, 0);
        check("R1 col", col_addr_out, 0);
        check("R1 row", row_addr_out, 0);
        rst_n = 1'b1;
        repeat (4) addr_q.push_back(2'b00);
        vsync = 1'b0; line_active = 1'b0;
        m_prev_vs = 0; m_prev_ln = 0;
        for (int s = 0; s < NSCEN; s++) begin
            for (int f = 0; f < FIELDS; f++) begin
                run_field(f == 0, modes[s], delays[s]);
            end
            if (s == 0) begin
                // R10: with jittered edges each field yields exactly one boundary
                check("R10 boundaries", oa_changes, FIELDS);
            end
        end
        summary();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        summary();
    end

endmodule